// File: doc/BRIEF.md
# Multi-Lane Pixel Frame Deserializer

This block rebuilds a 27-bit parallel pixel word from a serial stream. The word is 24 color bits and three sync/enable bits. Each pixel travels as a 30-bit frame, spread over one, two or three serial lanes. Every lane bit is qualified by a bit-valid strobe, all on one clock. The frame bits are collected in a single shift register. The block finds frame alignment by hunting for a start/stop pattern, then checks even parity before the word reaches the output bus.

A frame that passes the parity check replaces the word on the bus, and a regenerated pixel clock rises with it. A frame that fails is dropped: the bus keeps the previous word and a one-cycle error pulse is raised. A swap input mirrors the color fields on the bus for board routing. When the bit strobes stop, or framing breaks, the bus falls back to a fixed idle pattern. It leaves that pattern only after two consecutive well-framed frames.

Top module: `laneDeser`

## Requirements
- R1: While and after reset, with no frame yet received, `pixOut` is the idle pattern (bits 26..1 high, bit 0 low), `pclkOut` is low and `parityErr` is low.
- R2: A frame is 30 bits in transmission order. Index 0 is a start bit of 1. Indices 1..27 carry the data word MSB first (bit 26 first). Index 28 is an even-parity bit over the 27 data bits. Index 29 is a stop bit of 0. The data word holds red in bits 26..19, green in 18..11, blue in 10..3, vertical sync in bit 2, horizontal sync in bit 1 and data-enable in bit 0.
- R3: `laneMode` 1, 2 or 3 selects that many lanes, and 0 acts as 1. Frame index i travels on lane i mod N in the tick numbered i div N. A frame therefore spans 30/N ticks. Lanes at or above N are ignored.
- R4: When a frame ends with correct parity, `pixOut` shows its word in the cycle after the last tick's clock edge, and `parityErr` stays low.
- R5: When a frame ends with wrong parity, `parityErr` is high for exactly that one cycle. `pixOut` keeps the previous word.
- R6: With `swapOrder` high, bits 26..19 carry blue with bit 26 = B0, bits 18..11 carry green reversed, bits 10..3 carry red reversed (bit 3 = R7), and bits 2..0 are unchanged. With `swapOrder` low, the word appears as in R2.
- R7: After 64 consecutive clock cycles with `bitValid` low, the outputs go to the idle pattern with `pclkOut` low. After 63 such cycles the bus is unchanged.
- R8: After idle, the first well-framed frame leaves the bus idle. The second consecutive one is shown under R4/R5.
- R9: `pclkOut` rises in the same cycle a frame is shown and falls after tick floor(T/2) of the next frame, where T = 30/N. It is low while idle.
- R10: If a locked frame boundary shows a bad start or stop bit, the block drops to idle and hunts again, and R8 applies for recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one lane tick per cycle with `bitValid` high |
| rstN | input | 1 | Asynchronous reset, active low |
| bitValid | input | 1 | Qualifies `laneData` as one tick of serial bits |
| laneData | input | 3 | One serial bit per lane, lane 0 in bit 0 |
| laneMode | input | 2 | Active lane count (0 treated as 1) |
| swapOrder | input | 1 | Selects mirrored color field order on `pixOut` |
| pixOut | output | 27 | Parallel pixel word or idle pattern |
| pclkOut | output | 1 | Regenerated pixel clock |
| parityErr | output | 1 | One-cycle pulse on a dropped frame |

## Verification
The properties assume three things about the inputs. `laneMode` changes only while the block is idle. After idle, or after reset, the stream starts on a frame boundary. Within a running stream, gaps in `bitValid` are far shorter than the 64-cycle loss window. The stimulus keeps to these limits in several ways. It inserts random gaps of zero to two idle cycles between ticks. It switches lane mode only after forcing a clock loss, and it begins each stream with a fresh frame. Unused lanes and the swap input are randomized freely, since neither may affect framing.

// File: rtl/laneDeserPkg.sv
package laneDeserPkg;
  localparam int FRAME_BITS = 30;
  localparam int DATA_BITS  = 27;
  localparam int COLOR_BITS = 8;
  localparam int CTL_BITS   = 3;
  localparam int LANES      = 3;
  localparam int TICK_W     = $clog2(FRAME_BITS + 1);

  localparam logic [DATA_BITS-1:0] IDLE_WORD = {{(DATA_BITS-1){1'b1}}, 1'b0};

  typedef struct packed {
    logic shiftEn;
    logic loadWord;
    logic forceIdle;
  } deserStrobe_t;
endpackage

// File: rtl/laneDeserPath.sv
module laneDeserPath
  import laneDeserPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  deserStrobe_t         strobe,
  input  logic [LANES-1:0]     laneData,
  input  logic [1:0]           laneCount,
  input  logic                 swapOrder,
  output logic                 frameOk,
  output logic                 parityOk,
  output logic [DATA_BITS-1:0] pixOut
);
  logic [FRAME_BITS-1:0] shiftReg, nextShift;
  logic [DATA_BITS-1:0]  heldWord, dataWord, swappedWord;

  // newest lane bits enter at the LSB, lane 0 ahead of lane 1
  always_comb begin
    nextShift = shiftReg;
    for (int k = 0; k < LANES; k++) begin
      if (2'(k) < laneCount) nextShift = {nextShift[FRAME_BITS-2:0], laneData[k]};
    end
  end

  assign dataWord = nextShift[FRAME_BITS-2:2];
  assign parityOk = ~(^nextShift[FRAME_BITS-2:1]);
  assign frameOk  = nextShift[FRAME_BITS-1] & ~nextShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      heldWord <= IDLE_WORD;
    end else if (strobe.forceIdle) begin
      shiftReg <= '0;
      heldWord <= IDLE_WORD;
    end else begin
      if (strobe.shiftEn)  shiftReg <= nextShift;
      if (strobe.loadWord) heldWord <= dataWord;
    end
  end

  // mirrored order: field p takes field (2-p) with bits reversed
  for (genvar p = 0; p < 3; p++) begin : g_field
    for (genvar b = 0; b < COLOR_BITS; b++) begin : g_bit
      assign swappedWord[CTL_BITS + (2-p)*COLOR_BITS + b] =
        heldWord[CTL_BITS + p*COLOR_BITS + (COLOR_BITS-1-b)];
    end
  end
  assign swappedWord[CTL_BITS-1:0] = heldWord[CTL_BITS-1:0];

  assign pixOut = swapOrder ? swappedWord : heldWord;
endmodule

// File: rtl/laneDeserCtrl.sv
module laneDeserCtrl
  import laneDeserPkg::*;
#(
  parameter int LOSS_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitValid,
  input  logic [1:0]   laneCount,
  input  logic         frameOk,
  input  logic         parityOk,
  output deserStrobe_t strobe,
  output logic         pclkOut,
  output logic         parityErr
);
  localparam int GAP_W = $clog2(LOSS_CYCLES);

  logic [GAP_W-1:0]  gapCnt;
  logic [TICK_W-1:0] tickCnt, frameTicks, halfTicks, tickNext;
  logic [1:0]        goodCnt;
  logic              locked, active;
  logic              atBoundary, frameHit, frameFail, lossNow, showFrame;

  always_comb begin
    case (laneCount)
      2'd2:    frameTicks = TICK_W'(FRAME_BITS / 2);
      2'd3:    frameTicks = TICK_W'(FRAME_BITS / 3);
      default: frameTicks = TICK_W'(FRAME_BITS);
    endcase
    halfTicks  = frameTicks >> 1;
    tickNext   = tickCnt + 1'b1;
    atBoundary = locked && (tickCnt == frameTicks - 1'b1);
    frameHit   = bitValid && (!locked || atBoundary) && frameOk;
    frameFail  = bitValid && atBoundary && !frameOk;
    lossNow    = !bitValid && (gapCnt == GAP_W'(LOSS_CYCLES - 1));
    showFrame  = active || (goodCnt == 2'd1);
    strobe.shiftEn   = bitValid;
    strobe.loadWord  = frameHit && showFrame && parityOk;
    strobe.forceIdle = frameFail || lossNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt    <= '0;
      tickCnt   <= '0;
      goodCnt   <= '0;
      locked    <= 1'b0;
      active    <= 1'b0;
      pclkOut   <= 1'b0;
      parityErr <= 1'b0;
    end else begin
      parityErr <= frameHit && showFrame && !parityOk;
      if (bitValid)      gapCnt <= '0;
      else if (!lossNow) gapCnt <= gapCnt + 1'b1;

      if (strobe.forceIdle) begin
        locked  <= 1'b0;
        tickCnt <= '0;
        goodCnt <= '0;
        active  <= 1'b0;
        pclkOut <= 1'b0;
      end else if (frameHit) begin
        locked  <= 1'b1;
        tickCnt <= '0;
        if (!active) goodCnt <= goodCnt + 1'b1;
        if (showFrame) begin
          active  <= 1'b1;
          pclkOut <= 1'b1;
        end
      end else if (bitValid && locked) begin
        tickCnt <= tickNext;
        if (tickNext == halfTicks) pclkOut <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/laneDeser.sv
module laneDeser
  import laneDeserPkg::*;
#(
  parameter int LOSS_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitValid,
  input  logic [LANES-1:0]     laneData,
  input  logic [1:0]           laneMode,
  input  logic                 swapOrder,
  output logic [DATA_BITS-1:0] pixOut,
  output logic                 pclkOut,
  output logic                 parityErr
);
  deserStrobe_t strobe;
  logic         frameOk, parityOk;
  logic [1:0]   laneCount;

  assign laneCount = (laneMode == 2'd0) ? 2'd1 : laneMode;

  laneDeserCtrl #(.LOSS_CYCLES(LOSS_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitValid  (bitValid),
    .laneCount (laneCount),
    .frameOk   (frameOk),
    .parityOk  (parityOk),
    .strobe    (strobe),
    .pclkOut   (pclkOut),
    .parityErr (parityErr)
  );

  laneDeserPath u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .laneData  (laneData),
    .laneCount (laneCount),
    .swapOrder (swapOrder),
    .frameOk   (frameOk),
    .parityOk  (parityOk),
    .pixOut    (pixOut)
  );
endmodule

// File: rtl/laneDeserChk.sv
module laneDeserChk
  import laneDeserPkg::*;
#(
  parameter int LOSS_CYCLES = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 bitValid,
  input logic                 swapOrder,
  input logic [DATA_BITS-1:0] pixOut,
  input logic                 pclkOut,
  input logic                 parityErr
);
  localparam int CNT_W = $clog2(LOSS_CYCLES + 1);
  logic [CNT_W-1:0] quietCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  quietCnt <= '0;
    else if (bitValid)                          quietCnt <= '0;
    else if (quietCnt != CNT_W'(LOSS_CYCLES))   quietCnt <= quietCnt + 1'b1;
  end

  assert_errOneCycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> !parityErr);

  assert_holdOnErr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && $stable(swapOrder)) |-> $stable(pixOut));

  assert_lossIdle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt == CNT_W'(LOSS_CYCLES)) |-> (pixOut == IDLE_WORD && !pclkOut && !parityErr));

  assert_errWithPclk_R9: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> pclkOut);
endmodule

bind laneDeser laneDeserChk #(.LOSS_CYCLES(LOSS_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitValid  (bitValid),
  .swapOrder (swapOrder),
  .pixOut    (pixOut),
  .pclkOut   (pclkOut),
  .parityErr (parityErr)
);

// File: tb/laneDeser_tb.sv
module laneDeser_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [26:0] IDLE = {{26{1'b1}}, 1'b0};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitValid = 1'b0;
  logic [2:0]  laneData = '0;
  logic [1:0]  laneMode = 2'd1;
  logic        swapOrder = 1'b0;
  logic [26:0] pixOut;
  logic        pclkOut, parityErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [26:0] curWord;

  always #(CLK_PERIOD/2) clk = ~clk;

  laneDeser u_dut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .laneData(laneData),
    .laneMode(laneMode), .swapOrder(swapOrder), .pixOut(pixOut),
    .pclkOut(pclkOut), .parityErr(parityErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [26:0] expBus(input logic [26:0] w, input logic s);
    if (!s) return w;
    return {rev8(w[10:3]), rev8(w[18:11]), rev8(w[26:19]), w[2:0]};
  endfunction

  function automatic logic [29:0] mkFrame(input logic [26:0] d, input logic badPar, input logic badStop);
    logic [29:0] f;
    f[0] = 1'b1;
    for (int j = 0; j < 27; j++) f[1+j] = d[26-j];
    f[28] = (^d) ^ badPar;
    f[29] = badStop;
    return f;
  endfunction

  function automatic int laneN(input logic [1:0] m);
    return (m == 2'd0) ? 1 : int'(m);
  endfunction

  // ticks from..to-1 of frame f, random short gaps between ticks
  task automatic sendRange(input logic [29:0] f, input int from, input int to);
    int n = laneN(laneMode);
    for (int t = from; t < to; t++) begin
      logic [2:0] ld = 3'($urandom);
      for (int k = 0; k < n; k++) ld[k] = f[t*n + k];
      laneData = ld;
      bitValid = 1'b1;
      @(negedge clk);
      bitValid = 1'b0;
      if (t < to - 1) begin
        int g = $urandom % 3;
        for (int i = 0; i < g; i++) @(negedge clk);
      end
    end
  endtask

  task automatic sendFrame(input logic [29:0] f);
    sendRange(f, 0, 30 / laneN(laneMode));
  endtask

  task automatic quiet(input int cycles);
    bitValid = 1'b0;
    for (int i = 0; i < cycles; i++) @(negedge clk);
  endtask

  // two good frames out of idle; the first must not show
  task automatic resume(input string req);
    logic [26:0] a = 27'($urandom);
    logic [26:0] b = 27'($urandom);
    sendFrame(mkFrame(a, 1'b0, 1'b0));
    chk({req, " first frame stays idle R8"}, 32'(pixOut), 32'(IDLE));
    chk({req, " pclk low after first frame R8"}, 32'(pclkOut), 32'd0);
    sendFrame(mkFrame(b, 1'b0, 1'b0));
    curWord = b;
    chk({req, " second frame shown R8 R4"}, 32'(pixOut), 32'(expBus(b, swapOrder)));
    chk({req, " pclk rises R9"}, 32'(pclkOut), 32'd1);
    chk({req, " no error R4"}, 32'(parityErr), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R1 idle bus in reset", 32'(pixOut), 32'(IDLE));
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle bus after reset", 32'(pixOut), 32'(IDLE));
    chk("R1 pclk low", 32'(pclkOut), 32'd0);
    chk("R1 error low", 32'(parityErr), 32'd0);

    for (int m = 1; m <= 3; m++) begin
      int half;
      logic [26:0] d;
      laneMode = 2'(m);
      half = (30 / m) / 2;
      resume("R3 mode");
      for (int i = 0; i < 10; i++) begin
        logic bad = ($urandom % 4) == 0;
        swapOrder = 1'($urandom);
        d = 27'($urandom);
        sendFrame(mkFrame(d, bad, 1'b0));
        if (bad) begin
          chk("R5 error pulse high", 32'(parityErr), 32'd1);
          chk("R5 previous word held", 32'(pixOut), 32'(expBus(curWord, swapOrder)));
          @(negedge clk);
          chk("R5 error pulse one cycle", 32'(parityErr), 32'd0);
        end else begin
          curWord = d;
          chk("R2 R3 R6 word on bus", 32'(pixOut), 32'(expBus(d, swapOrder)));
          chk("R4 no error", 32'(parityErr), 32'd0);
        end
      end
      // pclk falls at tick half of the following frame
      d = 27'($urandom);
      sendRange(mkFrame(d, 1'b0, 1'b0), 0, half - 1);
      chk("R9 pclk high before half", 32'(pclkOut), 32'd1);
      sendRange(mkFrame(d, 1'b0, 1'b0), half - 1, half);
      chk("R9 pclk low at half", 32'(pclkOut), 32'd0);
      sendRange(mkFrame(d, 1'b0, 1'b0), half, 30 / m);
      curWord = d;
      chk("R9 pclk rises on word", 32'(pclkOut), 32'd1);
      // loss boundary
      quiet(63);
      chk("R7 held after 63 quiet cycles", 32'(pixOut), 32'(expBus(curWord, swapOrder)));
      quiet(1);
      chk("R7 idle after 64 quiet cycles", 32'(pixOut), 32'(IDLE));
      chk("R7 R9 pclk low when idle", 32'(pclkOut), 32'd0);
    end

    // mode value 0 behaves as one lane
    laneMode = 2'd0;
    swapOrder = 1'b0;
    resume("R3 mode zero");

    // directed mirror pattern
    sendFrame(mkFrame({8'h01, 8'h02, 8'h80, 3'b101}, 1'b0, 1'b0));
    chk("R6 unswapped order", 32'(pixOut), 32'({8'h01, 8'h02, 8'h80, 3'b101}));
    swapOrder = 1'b1;
    @(negedge clk);
    chk("R6 swapped order", 32'(pixOut), 32'({8'h01, 8'h40, 8'h80, 3'b101}));
    curWord = {8'h01, 8'h02, 8'h80, 3'b101};

    // gap well under the window keeps the stream locked
    quiet(60);
    chk("R7 short gap holds bus", 32'(pixOut), 32'(expBus(curWord, 1'b1)));
    sendFrame(mkFrame(27'h5A5A5A5, 1'b0, 1'b0));
    chk("R7 stream continues after gap", 32'(pixOut), 32'(expBus(27'h5A5A5A5, 1'b1)));

    // broken stop bit
    sendFrame(mkFrame(27'h1234567, 1'b0, 1'b1));
    chk("R10 framing loss forces idle", 32'(pixOut), 32'(IDLE));
    chk("R10 pclk low on framing loss", 32'(pclkOut), 32'd0);
    resume("R10 recovery");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule